// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block is the transmit-side DMA engine of an Ethernet MAC. Software fills a ring of two-word descriptors kept inside the block: one word holds a buffer byte address, the other a control/status word. A single-cycle `kick` strobe starts a scan. The engine walks the ring from its current head, transmits every descriptor that hardware owns, and reads the frame bytes through a simple byte-wide memory port with a one-cycle read latency. The bytes leave on a valid/ready byte stream with an end-of-frame marker and a sideband flag that asks the downstream MAC not to append a CRC.

When the engine finishes a descriptor, it writes the status back into the control word. It sets the ownership bit, which returns the descriptor to software, and adds any error flags for running out of descriptors in mid-frame, a buffer underrun or a retry limit. A halt request lets the frame in flight finish and then stops the scan. `xmit_busy` stays high for as long as the engine is not idle.

Top module: `tx_ring_reader`

## Requirements
- R1: After reset, every control word reads 0x8000_0000 except the one at index NDESC-1, which reads 0xC000_0000. Every address word reads 0. `xmit_busy` and `st_valid` are low.
- R2: A descriptor owned by hardware transmits N bytes, where N is the control word bits [10:0]. Byte i is read from buffer address (address word + i), in increasing order, and is emitted on `st_data`.
- R3: `st_last` is high only on the final byte of a descriptor whose control bit 15 (end of frame) is set, except in the error cases of R8 and R9.
- R4: Control bit 16 (no CRC) of a descriptor is presented on `st_nocrc` with every byte of that descriptor.
- R5: A descriptor whose control bit 31 (used) is set is not transmitted, and the scan stops at it.
- R6: When a descriptor completes, bit 31 of its control word is set and all other bits keep their values unless an error bit of R8 to R10 is added.
- R7: After a descriptor with control bit 30 (wrap) set, the scan continues at index 0. Otherwise it continues at index + 1, modulo NDESC.
- R8: If the final byte of a descriptor without bit 15 is reached while the next descriptor has bit 31 set, that byte carries `st_last` and bit 27 is set in the current descriptor.
- R9: A byte returned with `buf_err` high is emitted with `st_last`. The rest of that descriptor is skipped, bit 28 is set in it, and the scan ends even if later descriptors are owned by hardware.
- R10: A `retry_hit` pulse while a descriptor's bytes are being moved sets bit 29 in that descriptor's status.
- R11: After `halt_req`, the frame in flight finishes and the engine goes idle before the next frame. Untouched descriptors keep bit 31 clear until a later `kick`.
- R12: A `kick` that arrives while the engine is busy is remembered, and a fresh scan starts after the current one ends.
- R13: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_data`, `st_last` and `st_nocrc` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | Start-scan strobe |
| halt_req | input | 1 | Halt-after-frame strobe |
| xmit_busy | output | 1 | Engine not idle |
| dsc_we | input | 1 | Descriptor word write enable |
| dsc_sel | input | 1 | Word select: 1 control, 0 address |
| dsc_idx | input | $clog2(NDESC) | Descriptor index for write and read |
| dsc_wdata | input | 32 | Descriptor write data |
| dsc_rdata | output | 32 | Selected descriptor word |
| buf_rd | output | 1 | Buffer byte read request |
| buf_addr | output | AW | Buffer byte address |
| buf_rdata | input | 8 | Read data, one cycle after request |
| buf_err | input | 1 | Underrun flag, aligned with read data |
| retry_hit | input | 1 | Retry limit reached on current descriptor |
| st_valid | output | 1 | Stream byte valid |
| st_ready | input | 1 | Stream byte accepted |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | Final byte of frame |
| st_nocrc | output | 1 | Suppress CRC for this frame |

## Verification
The ring is driven with single-descriptor frames and with frames spread over two descriptors, using both a ready that is always high and one that stalls at random. These show whether byte order, the end-of-frame marker and the no-CRC sideband follow each descriptor, and whether stalls corrupt held data. A ring that wraps through a descriptor with the wrap flag, placed before an index that is still used, separates a correct wrap from a plain increment. The error patterns (next descriptor used in mid-frame, a read error on the third byte, a retry pulse) each leave a distinct status bit and a truncated stream. The halt and busy-kick cases are told apart by which later descriptors stay owned by hardware and by how often `xmit_busy` rises.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int DW      = 32;
  localparam int LW      = 11;
  localparam int B_LAST  = 15;
  localparam int B_NOCRC = 16;
  localparam int B_EXH   = 27;
  localparam int B_UND   = 28;
  localparam int B_RTY   = 29;
  localparam int B_WRAP  = 30;
  localparam int B_USED  = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FETCH,
    ST_RESP,
    ST_SEND,
    ST_WBACK
  } tdr_state_e;
endpackage

// File: rtl/tdr_desc_store.sv
module tdr_desc_store
  import tdr_pkg::*;
#(
  parameter int NDESC = 16,
  parameter int IW    = $clog2(NDESC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic          sw_sel,
  input  logic [IW-1:0] sw_idx,
  input  logic [DW-1:0] sw_wdata,
  output logic [DW-1:0] sw_rdata,
  input  logic [IW-1:0] cur_idx,
  output logic [DW-1:0] cur_ctrl,
  output logic [DW-1:0] cur_addr,
  input  logic [IW-1:0] nxt_idx,
  output logic [DW-1:0] nxt_ctrl,
  input  logic          hw_we,
  input  logic [DW-1:0] hw_set
);
  logic [NDESC-1:0][DW-1:0] ctrl_vec;
  logic [NDESC-1:0][DW-1:0] addr_vec;

  for (genvar g = 0; g < NDESC; g++) begin : g_ent
    localparam logic [DW-1:0] RST_CTRL = (g == NDESC - 1) ?
      ((DW'(1) << B_USED) | (DW'(1) << B_WRAP)) : (DW'(1) << B_USED);
    logic [DW-1:0] ctrl_q, ctrl_d, addr_q;
    logic          ctrl_en, addr_en;

    always_comb begin
      ctrl_en = 1'b0;
      ctrl_d  = ctrl_q;
      if (hw_we && cur_idx == IW'(g)) begin
        ctrl_en = 1'b1;
        ctrl_d  = ctrl_q | hw_set;
      end else if (sw_we && sw_sel && sw_idx == IW'(g)) begin
        ctrl_en = 1'b1;
        ctrl_d  = sw_wdata;
      end
      addr_en = sw_we && !sw_sel && sw_idx == IW'(g);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= RST_CTRL;
      end else if (ctrl_en) begin
        ctrl_q <= ctrl_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
      end else if (addr_en) begin
        addr_q <= sw_wdata;
      end
    end

    assign ctrl_vec[g] = ctrl_q;
    assign addr_vec[g] = addr_q;
  end

  assign sw_rdata = sw_sel ? ctrl_vec[sw_idx] : addr_vec[sw_idx];
  assign cur_ctrl = ctrl_vec[cur_idx];
  assign cur_addr = addr_vec[cur_idx];
  assign nxt_ctrl = ctrl_vec[nxt_idx];

  logic [IW-1:0] chk_idx_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_idx_q <= '0;
    else        chk_idx_q <= cur_idx;
  end

  // R6: a writeback leaves the descriptor owned by software
  assert_handback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_we |=> ctrl_vec[chk_idx_q][B_USED]);
endmodule

// File: rtl/tdr_stream_reg.sv
module tdr_stream_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [7:0] ld_data,
  input  logic       ld_last,
  input  logic       ld_nocrc,
  input  logic       st_ready,
  output logic       st_valid,
  output logic [7:0] st_data,
  output logic       st_last,
  output logic       st_nocrc,
  output logic       accept
);
  logic       valid_q, valid_d;
  logic [7:0] data_q, data_d;
  logic       last_q, last_d, nocrc_q, nocrc_d;

  always_comb begin
    valid_d = valid_q & ~st_ready;
    data_d  = data_q;
    last_d  = last_q;
    nocrc_d = nocrc_q;
    if (ld) begin
      valid_d = 1'b1;
      data_d  = ld_data;
      last_d  = ld_last;
      nocrc_d = ld_nocrc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
      nocrc_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (ld) begin
        data_q  <= data_d;
        last_q  <= last_d;
        nocrc_q <= nocrc_d;
      end
    end
  end

  assign st_valid = valid_q;
  assign st_data  = data_q;
  assign st_last  = last_q;
  assign st_nocrc = nocrc_q;
  assign accept   = valid_q & st_ready;

  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data) &&
                                 $stable(st_last) && $stable(st_nocrc)));
endmodule

// File: rtl/tdr_engine.sv
module tdr_engine
  import tdr_pkg::*;
#(
  parameter int NDESC = 16,
  parameter int AW    = 32,
  parameter int IW    = $clog2(NDESC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic          halt_req,
  input  logic          retry_hit,
  input  logic          buf_err,
  input  logic [DW-1:0] cur_ctrl,
  input  logic [DW-1:0] cur_addr,
  input  logic [DW-1:0] nxt_ctrl,
  input  logic          accept,
  output logic [IW-1:0] cur_idx,
  output logic [IW-1:0] nxt_idx,
  output logic          wb_we,
  output logic [DW-1:0] wb_set,
  output logic          buf_rd,
  output logic [AW-1:0] buf_addr,
  output logic          ld,
  output logic          ld_last,
  output logic          ld_nocrc,
  output logic          busy
);
  tdr_state_e    state_q, state_d;
  logic [IW-1:0] head_q, head_d;
  logic [LW-1:0] cnt_q, cnt_d, len_q, len_d;
  logic [AW-1:0] base_q, base_d;
  logic          last_q, last_d, nocrc_q, nocrc_d, wrap_q, wrap_d;
  logic          in_frame_q, in_frame_d;
  logic          und_q, und_d, exh_q, exh_d, rty_q, rty_d;
  logic          start_pend_q, start_pend_d, halt_pend_q, halt_pend_d;
  logic          final_byte, active, frame_end, exh_now;

  assign nxt_idx    = wrap_q ? '0 : head_q + 1'b1;
  assign final_byte = (cnt_q == len_q - 1'b1);
  assign active     = (state_q == ST_FETCH) || (state_q == ST_RESP) || (state_q == ST_SEND);
  assign frame_end  = last_q | und_q | exh_q;
  assign exh_now    = final_byte & ~last_q & nxt_ctrl[B_USED];

  always_comb begin
    state_d      = state_q;
    head_d       = head_q;
    cnt_d        = cnt_q;
    len_d        = len_q;
    base_d       = base_q;
    last_d       = last_q;
    nocrc_d      = nocrc_q;
    wrap_d       = wrap_q;
    in_frame_d   = in_frame_q;
    und_d        = und_q;
    exh_d        = exh_q;
    rty_d        = rty_q | (retry_hit & active);
    start_pend_d = start_pend_q | kick;
    halt_pend_d  = halt_pend_q | halt_req;
    buf_rd       = 1'b0;
    ld           = 1'b0;
    ld_last      = 1'b0;
    wb_we        = 1'b0;
    wb_set       = '0;
    case (state_q)
      ST_IDLE: begin
        halt_pend_d  = 1'b0;
        start_pend_d = 1'b0;
        if (kick || start_pend_q) state_d = ST_SCAN;
      end
      ST_SCAN: begin
        if (halt_pend_q && !in_frame_q) begin
          state_d     = ST_IDLE;
          halt_pend_d = 1'b0;
        end else if (cur_ctrl[B_USED]) begin
          state_d = ST_IDLE;
        end else begin
          base_d  = cur_addr[AW-1:0];
          len_d   = cur_ctrl[LW-1:0];
          last_d  = cur_ctrl[B_LAST];
          nocrc_d = cur_ctrl[B_NOCRC];
          wrap_d  = cur_ctrl[B_WRAP];
          cnt_d   = '0;
          und_d   = 1'b0;
          exh_d   = 1'b0;
          rty_d   = 1'b0;
          state_d = (cur_ctrl[LW-1:0] == '0) ? ST_WBACK : ST_FETCH;
        end
      end
      ST_FETCH: begin
        buf_rd  = 1'b1;
        state_d = ST_RESP;
      end
      ST_RESP: begin
        ld      = 1'b1;
        und_d   = buf_err;
        exh_d   = exh_now;
        ld_last = (final_byte & last_q) | buf_err | exh_now;
        state_d = ST_SEND;
      end
      ST_SEND: begin
        if (accept) begin
          cnt_d   = cnt_q + 1'b1;
          state_d = (und_q || exh_q || final_byte) ? ST_WBACK : ST_FETCH;
        end
      end
      ST_WBACK: begin
        wb_we         = 1'b1;
        wb_set[B_USED] = 1'b1;
        wb_set[B_UND]  = und_q;
        wb_set[B_EXH]  = exh_q;
        wb_set[B_RTY]  = rty_q;
        head_d        = nxt_idx;
        in_frame_d    = ~frame_end;
        if (und_q) begin
          state_d = ST_IDLE;
        end else if (halt_pend_q && frame_end) begin
          state_d     = ST_IDLE;
          halt_pend_d = 1'b0;
        end else begin
          state_d = ST_SCAN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      head_q       <= '0;
      cnt_q        <= '0;
      len_q        <= '0;
      base_q       <= '0;
      last_q       <= 1'b0;
      nocrc_q      <= 1'b0;
      wrap_q       <= 1'b0;
      in_frame_q   <= 1'b0;
      und_q        <= 1'b0;
      exh_q        <= 1'b0;
      rty_q        <= 1'b0;
      start_pend_q <= 1'b0;
      halt_pend_q  <= 1'b0;
    end else begin
      state_q      <= state_d;
      head_q       <= head_d;
      cnt_q        <= cnt_d;
      len_q        <= len_d;
      base_q       <= base_d;
      last_q       <= last_d;
      nocrc_q      <= nocrc_d;
      wrap_q       <= wrap_d;
      in_frame_q   <= in_frame_d;
      und_q        <= und_d;
      exh_q        <= exh_d;
      rty_q        <= rty_d;
      start_pend_q <= start_pend_d;
      halt_pend_q  <= halt_pend_d;
    end
  end

  assign cur_idx  = head_q;
  assign buf_addr = base_q + AW'(cnt_q);
  assign ld_nocrc = nocrc_q;
  assign busy     = (state_q != ST_IDLE);

  assert_used_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && cur_ctrl[B_USED]) |=> (state_q == ST_IDLE));
  assert_halt_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && halt_pend_q && !in_frame_q) |=> !busy);
  assert_pend_kick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_pend_q) |=> (state_q == ST_SCAN));
endmodule

// File: rtl/tx_ring_reader.sv
module tx_ring_reader
  import tdr_pkg::*;
#(
  parameter int NDESC = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(NDESC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic          halt_req,
  output logic          xmit_busy,
  input  logic          dsc_we,
  input  logic          dsc_sel,
  input  logic [IW-1:0] dsc_idx,
  input  logic [31:0]   dsc_wdata,
  output logic [31:0]   dsc_rdata,
  output logic          buf_rd,
  output logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_rdata,
  input  logic          buf_err,
  input  logic          retry_hit,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [7:0]    st_data,
  output logic          st_last,
  output logic          st_nocrc
);
  logic [IW-1:0] cur_idx, nxt_idx;
  logic [DW-1:0] cur_ctrl, cur_addr, nxt_ctrl, wb_set;
  logic          wb_we, ld, ld_last, ld_nocrc, accept;

  tdr_desc_store #(.NDESC(NDESC), .IW(IW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (dsc_we),
    .sw_sel   (dsc_sel),
    .sw_idx   (dsc_idx),
    .sw_wdata (dsc_wdata),
    .sw_rdata (dsc_rdata),
    .cur_idx  (cur_idx),
    .cur_ctrl (cur_ctrl),
    .cur_addr (cur_addr),
    .nxt_idx  (nxt_idx),
    .nxt_ctrl (nxt_ctrl),
    .hw_we    (wb_we),
    .hw_set   (wb_set)
  );

  tdr_engine #(.NDESC(NDESC), .AW(AW), .IW(IW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick      (kick),
    .halt_req  (halt_req),
    .retry_hit (retry_hit),
    .buf_err   (buf_err),
    .cur_ctrl  (cur_ctrl),
    .cur_addr  (cur_addr),
    .nxt_ctrl  (nxt_ctrl),
    .accept    (accept),
    .cur_idx   (cur_idx),
    .nxt_idx   (nxt_idx),
    .wb_we     (wb_we),
    .wb_set    (wb_set),
    .buf_rd    (buf_rd),
    .buf_addr  (buf_addr),
    .ld        (ld),
    .ld_last   (ld_last),
    .ld_nocrc  (ld_nocrc),
    .busy      (xmit_busy)
  );

  tdr_stream_reg u_stream (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (ld),
    .ld_data  (buf_rdata),
    .ld_last  (ld_last),
    .ld_nocrc (ld_nocrc),
    .st_ready (st_ready),
    .st_valid (st_valid),
    .st_data  (st_data),
    .st_last  (st_last),
    .st_nocrc (st_nocrc),
    .accept   (accept)
  );

  // R13: a read is issued only once the output byte has drained
  assert_fetch_empty_R13: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd |-> !st_valid);
  // R2: an idle engine neither reads nor emits
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !xmit_busy |-> (!buf_rd && !st_valid));
endmodule

// File: tb/tx_ring_reader_tb.sv
module tx_ring_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDESC = 16;
  localparam int AW = 32;

  logic        clk, rst_n, kick, halt_req, xmit_busy;
  logic        dsc_we, dsc_sel;
  logic [3:0]  dsc_idx;
  logic [31:0] dsc_wdata, dsc_rdata;
  logic        buf_rd, buf_err, retry_hit;
  logic [AW-1:0] buf_addr;
  logic [7:0]  buf_rdata;
  logic        st_valid, st_ready, st_last, st_nocrc;
  logic [7:0]  st_data;

  int checks = 0, fails = 0, rx_count = 0, go_rises = 0;
  logic [9:0] expq[$];
  bit rand_rdy = 0;
  bit err_en = 0;
  logic [AW-1:0] err_addr = '0;
  logic go_prev = 0, stall_prev = 0;
  logic [9:0] held_prev = '0;

  tx_ring_reader #(.NDESC(NDESC), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .kick(kick), .halt_req(halt_req),
    .xmit_busy(xmit_busy), .dsc_we(dsc_we), .dsc_sel(dsc_sel),
    .dsc_idx(dsc_idx), .dsc_wdata(dsc_wdata), .dsc_rdata(dsc_rdata),
    .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .buf_err(buf_err), .retry_hit(retry_hit), .st_valid(st_valid),
    .st_ready(st_ready), .st_data(st_data), .st_last(st_last),
    .st_nocrc(st_nocrc)
  );

  function automatic logic [7:0] byte_of(input logic [AW-1:0] a);
    logic [7:0] t;
    t = a[7:0];
    return t * 8'd13 + 8'd5;
  endfunction

  initial clk = 0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // buffer memory model: one-cycle read latency, error aligned with data
  always @(posedge clk) begin
    if (buf_rd) begin
      buf_rdata <= byte_of(buf_addr);
      buf_err   <= err_en && (buf_addr == err_addr);
    end else begin
      buf_err   <= 1'b0;
    end
  end

  initial begin
    st_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1 st_ready = rand_rdy ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop on handshake, hold check on stall (R13)
  always @(negedge clk) begin
    if (rst_n) begin
      if (xmit_busy && !go_prev) go_rises++;
      go_prev = xmit_busy;
      if (stall_prev)
        chk(st_valid && {st_last, st_nocrc, st_data} == held_prev, "R13 hold",
            {22'd0, st_last, st_nocrc, st_data}, {22'd0, held_prev});
      stall_prev = st_valid && !st_ready;
      held_prev  = {st_last, st_nocrc, st_data};
      if (st_valid && st_ready) begin
        rx_count++;
        if (expq.size() == 0) begin
          chk(0, "R2 unexpected byte", {22'd0, st_last, st_nocrc, st_data}, 32'd0);
        end else begin
          logic [9:0] e;
          e = expq.pop_front();
          chk({st_last, st_nocrc, st_data} == e, "R2/R3/R4 stream byte",
              {22'd0, st_last, st_nocrc, st_data}, {22'd0, e});
        end
      end
    end
  end

  task automatic dwr(input int idx, input bit sel, input logic [31:0] d);
    @(negedge clk);
    dsc_we = 1; dsc_sel = sel; dsc_idx = 4'(idx); dsc_wdata = d;
    @(negedge clk);
    dsc_we = 0;
  endtask

  task automatic drd(input int idx, input bit sel, output logic [31:0] v);
    @(negedge clk);
    dsc_idx = 4'(idx); dsc_sel = sel;
    #1 v = dsc_rdata;
  endtask

  task automatic setd(input int idx, input logic [31:0] a, input int len,
                      input bit last, input bit nocrc, input bit wrap);
    dwr(idx, 0, a);
    dwr(idx, 1, (32'(wrap) << 30) | (32'(nocrc) << 16) | (32'(last) << 15) | 32'(len));
  endtask

  task automatic push_run(input logic [AW-1:0] a, input int n, input bit last_end, input bit nocrc);
    for (int i = 0; i < n; i++)
      expq.push_back({(i == n - 1) && last_end, nocrc, byte_of(a + AW'(i))});
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1;
    @(negedge clk); kick = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (xmit_busy && n < 5000) begin
      @(negedge clk); n++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_ctrl(input int idx, input logic [31:0] exp, input string req);
    logic [31:0] v;
    drd(idx, 1, v);
    chk(v == exp, req, v, exp);
  endtask

  task automatic chk_drained(input string req);
    chk(expq.size() == 0, req, 32'(expq.size()), 32'd0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=busy expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base_rx, base_go;
    rst_n = 0; kick = 0; halt_req = 0; retry_hit = 0;
    dsc_we = 0; dsc_sel = 0; dsc_idx = '0; dsc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk(!xmit_busy && !st_valid, "R1 busy/valid", {30'd0, xmit_busy, st_valid}, 32'd0);
    chk_ctrl(0, 32'h8000_0000, "R1 ctrl0");
    chk_ctrl(15, 32'hC000_0000, "R1 ctrl15");
    drd(3, 0, v);
    chk(v == 32'd0, "R1 addr3", v, 32'd0);

    // R2 R3 R6: single descriptor frame
    setd(0, 32'h10, 5, 1, 0, 0);
    push_run(32'h10, 5, 1, 0);
    pulse_kick(); wait_idle();
    chk_drained("R2 frame0 drained");
    chk_ctrl(0, 32'h8000_8005, "R6 ctrl0 handback");

    // R4 R3: two-descriptor frame, random stalls
    rand_rdy = 1;
    setd(1, 32'h20, 3, 0, 1, 0);
    setd(2, 32'h40, 4, 1, 0, 0);
    push_run(32'h20, 3, 0, 1);
    push_run(32'h40, 4, 1, 0);
    pulse_kick(); wait_idle();
    chk_drained("R4 frame1 drained");
    chk_ctrl(1, 32'h8001_0003, "R6 ctrl1");
    chk_ctrl(2, 32'h8000_8004, "R6 ctrl2");
    rand_rdy = 0;

    // R5: head (index 3) still used
    base_rx = rx_count;
    pulse_kick(); wait_idle();
    chk(rx_count == base_rx, "R5 used not sent", 32'(rx_count), 32'(base_rx));

    // R7: wrap at index 3 back to 0 (index 4 still used)
    setd(3, 32'h50, 2, 1, 0, 1);
    setd(0, 32'h60, 3, 1, 0, 0);
    push_run(32'h50, 2, 1, 0);
    push_run(32'h60, 3, 1, 0);
    pulse_kick(); wait_idle();
    chk_drained("R7 wrap drained");
    chk_ctrl(3, 32'hC000_8002, "R7 ctrl3");
    chk_ctrl(0, 32'h8000_8003, "R7 ctrl0");

    // R8: mid-frame, next (index 2) used
    setd(1, 32'h70, 3, 0, 0, 0);
    push_run(32'h70, 3, 1, 0);
    pulse_kick(); wait_idle();
    chk_drained("R8 exhausted drained");
    chk_ctrl(1, 32'h8800_0003, "R8 ctrl1 exhausted");

    // R9: underrun on third byte, next descriptor owned by hardware
    err_en = 1; err_addr = 32'h82;
    setd(2, 32'h80, 6, 1, 0, 0);
    setd(3, 32'h90, 2, 1, 0, 0);
    push_run(32'h80, 3, 1, 0);
    pulse_kick(); wait_idle();
    err_en = 0;
    chk_drained("R9 underrun drained");
    chk_ctrl(2, 32'h9000_8006, "R9 ctrl2 underrun");
    chk_ctrl(3, 32'h0000_8002, "R9 scan ended");
    push_run(32'h90, 2, 1, 0);
    pulse_kick(); wait_idle();
    chk_drained("R9 resumed drained");

    // R10: retry pulse during descriptor 4
    setd(4, 32'hA0, 4, 1, 0, 0);
    push_run(32'hA0, 4, 1, 0);
    pulse_kick();
    @(negedge clk); retry_hit = 1;
    @(negedge clk); retry_hit = 0;
    wait_idle();
    chk_drained("R10 drained");
    chk_ctrl(4, 32'hA000_8004, "R10 ctrl4 retry");

    // R11: halt during first frame
    setd(5, 32'hB0, 3, 0, 0, 0);
    setd(6, 32'hC0, 2, 1, 0, 0);
    setd(7, 32'hD0, 2, 1, 0, 0);
    push_run(32'hB0, 3, 0, 0);
    push_run(32'hC0, 2, 1, 0);
    pulse_kick();
    @(negedge clk); halt_req = 1;
    @(negedge clk); halt_req = 0;
    wait_idle();
    chk_drained("R11 frame finished");
    chk_ctrl(7, 32'h0000_8002, "R11 next frame held");
    push_run(32'hD0, 2, 1, 0);
    pulse_kick(); wait_idle();
    chk_drained("R11 resumed drained");
    chk_ctrl(7, 32'h8000_8002, "R11 ctrl7");

    // R12: kick while busy launches a second scan
    setd(8, 32'hE0, 4, 1, 0, 0);
    push_run(32'hE0, 4, 1, 0);
    base_go = go_rises;
    pulse_kick();
    repeat (2) @(negedge clk);
    pulse_kick();
    wait_idle();
    repeat (4) @(negedge clk);
    chk_drained("R12 drained");
    chk(go_rises - base_go == 2, "R12 busy rises", 32'(go_rises - base_go), 32'd2);

    summary();
    $finish;
  end
endmodule